// File: doc/BRIEF.md
# Byte-Addressed Word Memory with Selectable Byte Order

This block is a small on-chip store of 32-bit words. Each address names one 8-bit byte, so the four bytes of a word sit at four consecutive addresses and words start on multiples of four. A requester presents an address, a write strobe, an access size (one byte or a whole word) and write data. Results come back on a registered read port, and a registered error flag marks rejected requests.

A static `big_endian` input selects how byte addresses map onto the bit positions of a word. The storage is kept by bit position: lane 0 holds bits 7:0 and lane 3 holds bits 31:24. In little-endian order, byte offset k in a word reaches lane k. In big-endian order it reaches lane 3-k. Whole-word accesses must be aligned. A word request whose two low address bits are not zero is refused: nothing is written, the read data is zero, and the error flag pulses.

Top module: `endian_byte_mem`

## Requirements
- R1: Byte address A selects word A>>2 and byte offset A[1:0]. Every word up to the highest address is stored separately, with no aliasing between words.
- R2: With `big_endian`=0, the byte at offset 0 of a word is bits 7:0 and the byte at offset 3 is bits 31:24.
- R3: With `big_endian`=1, the byte at offset 0 of a word is bits 31:24 and the byte at offset 3 is bits 7:0.
- R4: A word write followed by a word read of the same aligned address returns the written value.
- R5: A read leaves the stored contents unchanged, and it never raises any lane write.
- R6: A word request (`acc_size`=1) with `addr[1:0]`≠0 raises `err` in the cycle after it is accepted, for that one cycle only. Byte requests and aligned word requests never raise `err`.
- R7: A misaligned word request writes nothing, and its response data is zero.
- R8: A byte write (`acc_size`=0) replaces only the one lane that the offset and byte order select. The other three bytes of the word keep their values.
- R9: A byte read returns the selected byte in bits 7:0 of `rdata`, with bits 31:8 set to zero.
- R10: `rdata` is updated one clock after an accepted request (`req`=1) and holds its value while `req`=0. The response to a write is zero.
- R11: Synchronous active-high reset clears `rdata` and `err` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| big_endian | input | 1 | Byte order: 1 means the lowest address holds the most significant byte |
| req | input | 1 | Request accepted on this clock edge |
| we | input | 1 | 1 = write, 0 = read |
| acc_size | input | 1 | 0 = byte access, 1 = word access |
| addr | input | ADDR_W (8) | Byte address |
| wdata | input | 32 | Write data; a byte write uses bits 7:0 |
| rdata | output | 32 | Registered read data |
| err | output | 1 | Registered misalignment flag |

## Verification
A wrong lane choice shows up at the first byte read after a word write: the byte appears under a different offset. It also shows up at the first word read after a byte write, where the new byte lands in the wrong position of the word. A misaligned request that slips through corrupts storage silently, so it only becomes visible when that word is read back. The bench therefore reads every touched word again after a rejected request. A stale or missing `err` pulse is visible on the very next cycle.

// File: rtl/ebm_pkg.sv
package ebm_pkg;
    localparam int BYTE_W     = 8;
    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = BYTE_W * WORD_BYTES;
    localparam int OFF_W      = $clog2(WORD_BYTES);

    typedef enum logic {
        ACC_BYTE = 1'b0,
        ACC_WORD = 1'b1
    } acc_size_e;

    typedef struct packed {
        logic                  rd;
        logic                  misaligned;
        logic [OFF_W-1:0]      lane;
        logic [WORD_BYTES-1:0] lane_we;
    } access_t;

    // bit-position lane reached by a byte offset under the chosen order
    function automatic logic [OFF_W-1:0] lane_of(input logic [OFF_W-1:0] off,
                                                 input logic big);
        return big ? (OFF_W'(WORD_BYTES - 1) - off) : off;
    endfunction
endpackage

// File: rtl/ebm_decode.sv
module ebm_decode
    import ebm_pkg::*;
(
    input  logic             req,
    input  logic             we,
    input  acc_size_e        size,
    input  logic [OFF_W-1:0] off,
    input  logic             big_endian,
    output access_t          acc
);
    always_comb begin
        acc            = '0;
        acc.lane       = lane_of(off, big_endian);
        acc.misaligned = req && (size == ACC_WORD) && (off != '0);
        acc.rd         = req && !we && !acc.misaligned;
        if (req && we && !acc.misaligned) begin
            if (size == ACC_WORD) acc.lane_we = '1;
            else                  acc.lane_we = WORD_BYTES'(1) << acc.lane;
        end
    end
endmodule

// File: rtl/ebm_store.sv
module ebm_store
    import ebm_pkg::*;
#(
    parameter int WORDS = 64,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [IDX_W-1:0]      idx,
    input  logic [WORD_BYTES-1:0] lane_we,
    input  logic [WORD_W-1:0]     wlanes,
    output logic [WORD_W-1:0]     rword
);
    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
        logic [BYTE_W-1:0] bank [WORDS];
        always_ff @(posedge clk) begin
            if (lane_we[g]) bank[idx] <= wlanes[g*BYTE_W +: BYTE_W];
        end
        assign rword[g*BYTE_W +: BYTE_W] = bank[idx];
    end

    // R8: lane writes are none, exactly one, or all four
    a_r8_lane_we_shape: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lane_we) || (&lane_we));
endmodule

// File: rtl/ebm_format.sv
module ebm_format
    import ebm_pkg::*;
(
    input  access_t           acc,
    input  acc_size_e         size,
    input  logic [WORD_W-1:0] rword,
    output logic [WORD_W-1:0] rsp
);
    always_comb begin
        rsp = '0;
        if (acc.rd) begin
            if (size == ACC_WORD) rsp = rword;
            else                  rsp = WORD_W'(rword[acc.lane*BYTE_W +: BYTE_W]);
        end
    end
endmodule

// File: rtl/endian_byte_mem.sv
module endian_byte_mem
    import ebm_pkg::*;
#(
    parameter int WORDS = 64,
    localparam int IDX_W  = $clog2(WORDS),
    localparam int ADDR_W = IDX_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              big_endian,
    input  logic              req,
    input  logic              we,
    input  logic              acc_size,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              err
);
    acc_size_e         size;
    access_t           acc;
    logic [WORD_W-1:0] wlanes;
    logic [WORD_W-1:0] rword;
    logic [WORD_W-1:0] rsp;

    assign size   = acc_size_e'(acc_size);
    assign wlanes = (size == ACC_WORD) ? wdata : {WORD_BYTES{wdata[BYTE_W-1:0]}};

    ebm_decode u_dec (
        .req(req), .we(we), .size(size), .off(addr[OFF_W-1:0]),
        .big_endian(big_endian), .acc(acc)
    );

    ebm_store #(.WORDS(WORDS)) u_store (
        .clk(clk), .rst(rst), .idx(addr[ADDR_W-1:OFF_W]),
        .lane_we(acc.lane_we), .wlanes(wlanes), .rword(rword)
    );

    ebm_format u_fmt (.acc(acc), .size(size), .rword(rword), .rsp(rsp));

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
            err   <= 1'b0;
        end else begin
            err <= acc.misaligned;
            if (req) rdata <= rsp;
        end
    end

    // R6: a misaligned word request pulses err on the next cycle
    a_r6_err_on_misaligned: assert property (@(posedge clk) disable iff (rst)
        (req && acc_size && (addr[1:0] != 2'b00)) |=> err);
    // R6: no err for aligned or byte requests, or when idle
    a_r6_err_only_when_due: assert property (@(posedge clk) disable iff (rst)
        !(req && acc_size && (addr[1:0] != 2'b00)) |=> !err);
    // R7: a rejected request answers with zero data
    a_r7_zero_on_err: assert property (@(posedge clk) disable iff (rst)
        err |-> (rdata == '0));
    // R7: a rejected request raises no lane write
    a_r7_no_write_on_err: assert property (@(posedge clk) disable iff (rst)
        (req && acc_size && (addr[1:0] != 2'b00)) |-> (acc.lane_we == '0));
    // R5: reads never write
    a_r5_read_no_write: assert property (@(posedge clk) disable iff (rst)
        (req && !we) |-> (acc.lane_we == '0));
    // R10: idle cycles hold the response
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !req |=> $stable(rdata));
    // R9: byte reads have zero upper bits
    a_r9_zero_ext: assert property (@(posedge clk) disable iff (rst)
        (req && !acc_size) |=> (rdata[31:8] == '0));
endmodule

// File: tb/endian_byte_mem_test.sv
`timescale 1ns/1ps
module endian_byte_mem_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        big_endian;
    logic        req;
    logic        we;
    logic        acc_size;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        err;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    endian_byte_mem uut (
        .clk(clk), .rst(rst), .big_endian(big_endian), .req(req), .we(we),
        .acc_size(acc_size), .addr(addr), .wdata(wdata), .rdata(rdata), .err(err)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // drive a request at the falling edge; results sampled 2 ns after the capturing edge
    task automatic access(input logic w, input logic sz, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        req = 1'b1; we = w; acc_size = sz; addr = a; wdata = d;
        @(posedge clk);
        #2;
    endtask

    task automatic idle();
        @(negedge clk);
        req = 1'b0; we = 1'b0; wdata = 32'hDEAD_BEEF;
        @(posedge clk);
        #2;
    endtask

    task automatic t_reset();
        check("R11 rdata after reset", rdata, 32'h0);
        check("R11 err after reset", {31'b0, err}, 32'h0);
    endtask

    task automatic t_little();
        big_endian = 1'b0;
        access(1, 1, 8'd0, 32'h1122_3344);
        check("R10 write response zero", rdata, 32'h0);
        access(0, 1, 8'd0, 32'h0);
        check("R4 word readback LE", rdata, 32'h1122_3344);
        access(0, 0, 8'd0, 32'h0);
        check("R2 offset0 is bits 7:0", rdata, 32'h44);
        access(0, 0, 8'd3, 32'h0);
        check("R2 offset3 is bits 31:24", rdata, 32'h11);
        access(0, 0, 8'd1, 32'h0);
        check("R9 byte zero-extended", rdata, 32'h33);
    endtask

    task automatic t_big();
        big_endian = 1'b1;
        access(1, 1, 8'd4, 32'hA1B2_C3D4);
        access(0, 1, 8'd4, 32'h0);
        check("R4 word readback BE", rdata, 32'hA1B2_C3D4);
        access(0, 0, 8'd4, 32'h0);
        check("R3 offset0 is bits 31:24", rdata, 32'hA1);
        access(0, 0, 8'd7, 32'h0);
        check("R3 offset3 is bits 7:0", rdata, 32'hD4);
        access(0, 0, 8'd0, 32'h0);
        check("R3 BE view of LE-written word", rdata, 32'h11);
    endtask

    task automatic t_byte_write();
        big_endian = 1'b1;
        access(1, 0, 8'd5, 32'hFFFF_FF5A);
        access(0, 1, 8'd4, 32'h0);
        check("R8 BE byte write one lane", rdata, 32'hA15A_C3D4);
        big_endian = 1'b0;
        access(1, 0, 8'd1, 32'h0000_00EE);
        check("R10 byte write response zero", rdata, 32'h0);
        access(0, 1, 8'd0, 32'h0);
        check("R8 LE byte write one lane", rdata, 32'h1122_EE44);
    endtask

    task automatic t_misaligned();
        big_endian = 1'b0;
        access(1, 1, 8'd2, 32'hFFFF_FFFF);
        check("R6 err after misaligned write", {31'b0, err}, 32'h1);
        check("R7 zero data on misaligned", rdata, 32'h0);
        idle();
        check("R6 err lasts one cycle", {31'b0, err}, 32'h0);
        access(0, 1, 8'd0, 32'h0);
        check("R7 misaligned write suppressed", rdata, 32'h1122_EE44);
        check("R6 no err on aligned", {31'b0, err}, 32'h0);
        access(0, 1, 8'd6, 32'h0);
        check("R6 err after misaligned read", {31'b0, err}, 32'h1);
        check("R7 misaligned read data zero", rdata, 32'h0);
        access(0, 0, 8'd3, 32'h0);
        check("R6 byte at odd address no err", {31'b0, err}, 32'h0);
        check("R9 odd byte read", rdata, 32'h11);
    endtask

    task automatic t_nondestructive();
        big_endian = 1'b1;
        access(0, 1, 8'd4, 32'h0);
        access(0, 1, 8'd4, 32'h0);
        check("R5 repeated read unchanged", rdata, 32'hA15A_C3D4);
        idle();
        idle();
        check("R10 idle holds rdata", rdata, 32'hA15A_C3D4);
    endtask

    task automatic t_top_word();
        big_endian = 1'b0;
        access(1, 1, 8'd252, 32'hCAFE_F00D);
        access(0, 1, 8'd252, 32'h0);
        check("R1 highest word readback", rdata, 32'hCAFE_F00D);
        access(0, 0, 8'd255, 32'h0);
        check("R1 highest byte address", rdata, 32'hCA);
        access(0, 1, 8'd0, 32'h0);
        check("R1 no aliasing to word 0", rdata, 32'h1122_EE44);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; big_endian = 1'b0; req = 1'b0; we = 1'b0;
        acc_size = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_little();
        t_big();
        t_byte_write();
        t_misaligned();
        t_nondestructive();
        t_top_word();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule